// File: doc/BRIEF.md
# Fractional M/N Clock Enable Generator

This block sits after a clock root's integer pre-divider and turns the divided clock into an output that runs at m/n of its rate, with a programmable high time. Software writes three configuration words and a two-bit mode. The block decodes those words and runs a phase accumulator that advances by m each input cycle, modulo n. It emits one output pulse (`tick_o`) each time the accumulator wraps, so exactly m pulses come out for every n input cycles. A duty waveform (`wave_o`) is high for the part of each output period set by the duty word. In every mode other than the fractional one, the block passes the input clock straight through: `tick_o` and `wave_o` are held high.

The configuration words use an inverted encoding. The M word holds m directly. The N word holds the bitwise inverse of (n − m). The duty word holds the bitwise inverse of the threshold t; writing the inverse of n gives a high time of half the output period. A one-cycle `commit_i` pulse copies the decoded words into a pending copy. That copy becomes active only at the start of the next output period, so a period that is already running always finishes with its old setting.

Top module: `frac_clk_gen`

## Requirements
- R1: With a valid configuration in fractional mode, any window of n consecutive input cycles holds exactly m cycles with `tick_o` high, and `mn_active_o` is 1.
- R2: When the bypass configuration is active, `tick_o` and `wave_o` are 1 in every cycle and `mn_active_o` is 0. Mode values 0, 1 and 3 select bypass; only mode 2 selects the fractional path.
- R3: The words are decoded with W-bit masking: m is the M word; n is (~N & mask) + m, computed one bit wider. The threshold t is ~D & mask.
- R4: In fractional mode, `wave_o` is high in a cycle when twice the accumulator's post-step value is below t. For n consecutive cycles, the high count equals the number of values a_k = (k·m mod n), k = 1..n, with 2·a_k < t.
- R5: The block uses bypass in five cases: the decoded n is zero, m is zero, m exceeds n, the sum (~N & mask) + m carries out of W bits, or the mode is not 2.
- R6: A committed configuration becomes active one cycle after the commit if bypass is active. If the fractional path is active, it becomes active on the cycle whose step wraps the accumulator. Before that, the output keeps the old timing.
- R7: If a second commit arrives while a configuration is still pending, the later one replaces the earlier one.
- R8: While reset is asserted, `tick_o`, `wave_o` and `mn_active_o` are 0 and no configuration is pending. The first cycle after reset runs in bypass.
- R9: While the fractional path is active, the accumulator value is always below n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pre-divided source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_i | input | 1 | One-cycle pulse that captures the configuration words |
| mode_i | input | 2 | Path select: 2 = fractional, other values = bypass |
| m_word_i | input | W | M word, holds m |
| n_word_i | input | W | N word, holds ~(n − m) |
| d_word_i | input | W | Duty word, holds ~t |
| tick_o | output | 1 | One pulse per output cycle; constant 1 in bypass |
| wave_o | output | 1 | Duty-shaped output level; constant 1 in bypass |
| mn_active_o | output | 1 | Fractional path currently in use |

## Verification
The assertions assume that `commit_i` is a clean synchronous pulse and that the configuration words are stable in the cycle it is sampled. They also assume that the accumulator only ever starts from zero, which holds because every load clears it. The stimulus drives all inputs on the falling edge and raises `commit_i` for exactly one cycle. It uses raw random words, so overflowing, zero and inverted-order encodings occur naturally, and it decodes them by the rules in R3 and R5. Measurement windows open only after enough cycles for any pending configuration to load.

// File: rtl/mnd_pkg.sv
package mnd_pkg;
    typedef enum logic [1:0] {
        MODE_PASS0 = 2'd0,
        MODE_PASS1 = 2'd1,
        MODE_FRAC  = 2'd2,
        MODE_PASS3 = 2'd3
    } mnd_mode_e;
endpackage

// File: rtl/mnd_decode.sv
module mnd_decode
    import mnd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] m_word_i,
    input  logic [W-1:0] n_word_i,
    input  logic [W-1:0] d_word_i,
    output logic [W-1:0] m_o,
    output logic [W-1:0] n_o,
    output logic [W-1:0] thr_o,
    output logic         valid_o
);
    localparam int WX = W + 1;

    logic [WX-1:0] n_full;
    logic          frac_sel;

    always_comb begin
        // n is rebuilt from the inverted difference plus m, one bit wider
        n_full   = {1'b0, ~n_word_i} + {1'b0, m_word_i};
        frac_sel = (mnd_mode_e'(mode_i) == MODE_FRAC);
        m_o      = m_word_i;
        n_o      = n_full[W-1:0];
        thr_o    = ~d_word_i;
        valid_o  = frac_sel
                 && (m_word_i != '0)
                 && !n_full[WX-1]
                 && (n_full[W-1:0] != '0)
                 && (m_word_i <= n_full[W-1:0]);
    end
endmodule

// File: rtl/mnd_shadow.sv
module mnd_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_i,
    input  logic [W-1:0] dec_m_i,
    input  logic [W-1:0] dec_n_i,
    input  logic [W-1:0] dec_thr_i,
    input  logic         dec_valid_i,
    input  logic         wrap_i,
    output logic [W-1:0] act_m_o,
    output logic [W-1:0] act_n_o,
    output logic [W-1:0] act_thr_o,
    output logic         act_valid_o,
    output logic         pend_o,
    output logic         load_o
);
    typedef struct packed {
        logic [W-1:0] m;
        logic [W-1:0] n;
        logic [W-1:0] thr;
        logic         valid;
    } cfg_t;

    typedef struct packed {
        cfg_t pend_cfg;
        logic pend;
        cfg_t act_cfg;
    } shadow_t;

    shadow_t s_d, s_q;
    logic    load;

    always_comb begin
        s_d  = s_q;
        // a period boundary: every cycle in bypass, the wrap step otherwise
        load = s_q.pend && (!s_q.act_cfg.valid || wrap_i);
        if (load) begin
            s_d.act_cfg = s_q.pend_cfg;
            s_d.pend    = 1'b0;
        end
        if (commit_i) begin
            s_d.pend_cfg.m     = dec_m_i;
            s_d.pend_cfg.n     = dec_n_i;
            s_d.pend_cfg.thr   = dec_thr_i;
            s_d.pend_cfg.valid = dec_valid_i;
            s_d.pend           = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_m_o     = s_q.act_cfg.m;
    assign act_n_o     = s_q.act_cfg.n;
    assign act_thr_o   = s_q.act_cfg.thr;
    assign act_valid_o = s_q.act_cfg.valid;
    assign pend_o      = s_q.pend;
    assign load_o      = load;
endmodule

// File: rtl/mnd_phase.sv
module mnd_phase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         act_i,
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] n_i,
    input  logic [W-1:0] thr_i,
    input  logic         load_i,
    output logic         wrap_o,
    output logic [W-1:0] acc_o,
    output logic         tick_o,
    output logic         wave_o
);
    localparam int WX = W + 1;

    typedef struct packed {
        logic [W-1:0] acc;
        logic         tick;
        logic         wave;
    } phase_t;

    phase_t        p_d, p_q;
    logic [WX-1:0] sum;
    logic [WX-1:0] stepped;
    logic [W-1:0]  acc_nx;
    logic [WX-1:0] twice;
    logic          wrap;

    always_comb begin
        sum     = {1'b0, p_q.acc} + {1'b0, m_i};
        wrap    = act_i && (sum >= {1'b0, n_i});
        stepped = wrap ? (sum - {1'b0, n_i}) : sum;
        acc_nx  = stepped[W-1:0];
        twice   = {acc_nx, 1'b0};

        p_d = p_q;
        if (act_i) begin
            p_d.tick = wrap;
            p_d.wave = (twice < {1'b0, thr_i});
            p_d.acc  = acc_nx;
        end else begin
            p_d.tick = 1'b1;
            p_d.wave = 1'b1;
            p_d.acc  = '0;
        end
        if (load_i) begin
            p_d.acc = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign wrap_o = wrap;
    assign acc_o  = p_q.acc;
    assign tick_o = p_q.tick;
    assign wave_o = p_q.wave;
endmodule

// File: rtl/frac_clk_gen.sv
module frac_clk_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_i,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] m_word_i,
    input  logic [W-1:0] n_word_i,
    input  logic [W-1:0] d_word_i,
    output logic         tick_o,
    output logic         wave_o,
    output logic         mn_active_o
);
    logic [W-1:0] dec_m, dec_n, dec_thr;
    logic         dec_valid;
    logic [W-1:0] act_m, act_n, act_thr;
    logic         act_valid;
    logic         pend_w;
    logic         load_w;
    logic         wrap_w;
    logic [W-1:0] acc_w;

    mnd_decode #(.W(W)) i_decode (
        .mode_i   (mode_i),
        .m_word_i (m_word_i),
        .n_word_i (n_word_i),
        .d_word_i (d_word_i),
        .m_o      (dec_m),
        .n_o      (dec_n),
        .thr_o    (dec_thr),
        .valid_o  (dec_valid)
    );

    mnd_shadow #(.W(W)) i_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (commit_i),
        .dec_m_i     (dec_m),
        .dec_n_i     (dec_n),
        .dec_thr_i   (dec_thr),
        .dec_valid_i (dec_valid),
        .wrap_i      (wrap_w),
        .act_m_o     (act_m),
        .act_n_o     (act_n),
        .act_thr_o   (act_thr),
        .act_valid_o (act_valid),
        .pend_o      (pend_w),
        .load_o      (load_w)
    );

    mnd_phase #(.W(W)) i_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act_valid),
        .m_i    (act_m),
        .n_i    (act_n),
        .thr_i  (act_thr),
        .load_i (load_w),
        .wrap_o (wrap_w),
        .acc_o  (acc_w),
        .tick_o (tick_o),
        .wave_o (wave_o)
    );

    assign mn_active_o = act_valid;
endmodule

// File: rtl/mnd_checker.sv
module mnd_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         commit_i,
    input logic         tick_o,
    input logic         wave_o,
    input logic         act,
    input logic [W-1:0] acc,
    input logic [W-1:0] n_act,
    input logic         pend
);
    assert_bypass_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (tick_o && wave_o));

    assert_acc_below_n_R9: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (acc < n_act));

    assert_nonzero_n_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (n_act != '0));

    assert_hold_without_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> ($stable(n_act) && $stable(act)));

    assert_commit_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> pend);
endmodule

bind frac_clk_gen mnd_checker #(.W(W)) i_mnd_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (commit_i),
    .tick_o   (tick_o),
    .wave_o   (wave_o),
    .act      (mn_active_o),
    .acc      (acc_w),
    .n_act    (act_n),
    .pend     (pend_w)
);

// File: tb/test_frac_clk_gen.sv
`timescale 1ns/1ps
module test_frac_clk_gen;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         commit_i = 1'b0;
    logic [1:0]   mode_i = 2'd0;
    logic [W-1:0] m_word_i = '0;
    logic [W-1:0] n_word_i = '0;
    logic [W-1:0] d_word_i = '0;
    logic         tick_o, wave_o, mn_active_o;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    frac_clk_gen #(.W(W)) i_frac_clk_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_i    (commit_i),
        .mode_i      (mode_i),
        .m_word_i    (m_word_i),
        .n_word_i    (n_word_i),
        .d_word_i    (d_word_i),
        .tick_o      (tick_o),
        .wave_o      (wave_o),
        .mn_active_o (mn_active_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dec_n(input int m, input int nw);
        return ((~nw) & 255) + m;
    endfunction

    function automatic bit is_frac(input int mode, input int m, input int nw);
        int n = dec_n(m, nw);
        return (mode == 2) && (m != 0) && (n != 0) && (n <= 255) && (m <= n);
    endfunction

    function automatic int exp_high(input int m, input int n, input int t);
        int a = 0;
        int c = 0;
        for (int k = 0; k < n; k++) begin
            a = (a + m) % n;
            if (2 * a < t) c++;
        end
        return c;
    endfunction

    task automatic commit(input int mode, input int m, input int nw, input int dw);
        @(negedge clk);
        mode_i = 2'(mode); m_word_i = W'(m); n_word_i = W'(nw); d_word_i = W'(dw);
        commit_i = 1'b1;
        @(negedge clk);
        commit_i = 1'b0;
    endtask

    task automatic measure(input int mode, input int m, input int nw, input int dw, input string tag);
        int ticks = 0;
        int highs = 0;
        int len;
        bit fr = is_frac(mode, m, nw);
        int n = dec_n(m, nw);
        len = fr ? 4 * n : 64;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ticks += int'(tick_o);
            highs += int'(wave_o);
        end
        if (fr) begin
            check(ticks == 4 * m, {tag, " R1 ticks"}, ticks, 4 * m);
            check(highs == 4 * exp_high(m, n, (~dw) & 255), {tag, " R4 duty"}, highs,
                  4 * exp_high(m, n, (~dw) & 255));
            check(mn_active_o == 1'b1, {tag, " R3 active"}, int'(mn_active_o), 1);
        end else begin
            check(ticks == len, {tag, " R2/R5 ticks"}, ticks, len);
            check(highs == len, {tag, " R2/R5 wave"}, highs, len);
            check(mn_active_o == 1'b0, {tag, " R5 bypass"}, int'(mn_active_o), 0);
        end
    endtask

    task automatic run_cfg(input int mode, input int m, input int nw, input int dw, input string tag);
        commit(mode, m, nw, dw);
        repeat (520) @(negedge clk);
        measure(mode, m, nw, dw, tag);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        int seen;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R8: reset state
        check(tick_o == 1'b0, "R8 tick in reset", int'(tick_o), 0);
        check(wave_o == 1'b0, "R8 wave in reset", int'(wave_o), 0);
        check(mn_active_o == 1'b0, "R8 active in reset", int'(mn_active_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tick_o == 1'b1, "R8 bypass after reset", int'(tick_o), 1);

        // R6: from bypass, load one cycle after commit
        @(negedge clk);
        mode_i = 2'd2; m_word_i = 8'd3; n_word_i = ~8'd5; d_word_i = ~8'd8;
        commit_i = 1'b1;
        @(negedge clk);
        commit_i = 1'b0;
        check(mn_active_o == 1'b0, "R6 not yet active", int'(mn_active_o), 0);
        @(negedge clk);
        check(mn_active_o == 1'b1, "R6 active after one cycle", int'(mn_active_o), 1);
        repeat (20) @(negedge clk);
        measure(2, 3, ~8 & 255 ^ 0 | 0 ? (~5 & 255) : (~5 & 255), ~8 & 255, "m3n8 half duty");

        // directed corner cases
        run_cfg(0, 3, ~5 & 255, ~8 & 255, "mode0 R2");
        run_cfg(1, 3, ~5 & 255, ~8 & 255, "mode1 R2");
        run_cfg(3, 3, ~5 & 255, ~8 & 255, "mode3 R2");
        run_cfg(2, 0, 255, 0, "n zero R5");
        run_cfg(2, 5, 4, 0, "m above n R5");
        run_cfg(2, 0, ~10 & 255, 0, "m zero R5");
        run_cfg(2, 7, 255, ~7 & 255, "m equals n R1");
        run_cfg(2, 1, ~254 & 255, ~255 & 255, "n 255 R3");

        // R6 and R7: deferral to the wrap, and the later commit wins
        run_cfg(2, 1, ~99 & 255, ~100 & 255, "slow m1n100");
        seen = 0;
        while (seen == 0) begin
            @(negedge clk);
            seen = int'(tick_o);
        end
        commit(2, 1, ~1 & 255, ~2 & 255);
        seen = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            seen += int'(tick_o);
        end
        commit(2, 1, ~3 & 255, ~4 & 255);
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            seen += int'(tick_o);
        end
        check(seen == 0, "R6 old period kept", seen, 0);
        check(mn_active_o == 1'b1, "R6 still active", int'(mn_active_o), 1);
        repeat (40) @(negedge clk);
        measure(2, 1, ~3 & 255, ~4 & 255, "R7 latest commit");

        // random configurations
        for (int it = 0; it < 40; it++) begin
            int mode = ($urandom % 4 == 0) ? int'($urandom % 4) : 2;
            int m = int'($urandom % 256);
            int nw = int'($urandom % 256);
            int dw = int'($urandom % 256);
            if ($urandom % 2 == 0) begin
                int n = 1 + int'($urandom % 255);
                m = 1 + int'($urandom % n);
                nw = (~(n - m)) & 255;
            end
            run_cfg(mode, m, nw, dw, "random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule